// File: doc/BRIEF.md
# Programmable Display Timing Generator

This block produces the raster timing for one display channel. Software programs four timing registers and one control register through a simple write port. The timing registers set, per axis, the total length, the end of the visible area, the start of sync and its length. The generator then runs a pixel counter and a line counter. From these it drives horizontal sync, vertical sync, a data-enable strobe and the current pixel coordinates. Pixel-clock synthesis, the frame-buffer fetch and the pixel data path sit outside the block.

The control register holds five settings: timing enable, plane enable, the two sync polarities and a pixel-clock edge select. A write to it lands first in a pending copy. The live copy, which drives the outputs and is read back on `ctrl_rd`, takes the pending value at the start of the next vertical sync period. Software that needs to know when a change is in force polls `ctrl_rd` until it matches. There is one exception: while the live timing enable is clear there is no raster to wait for, so the pending value is applied at once.

Top module: `disp_timing_gen`

## Requirements
- R1: Register 0 holds the horizontal total minus one in bits [27:16], and register 2 holds the vertical total minus one in the same bits. While timing runs, `pix_x` counts 0 up to the horizontal total field and then wraps to 0. `pix_y` advances by one at each such wrap, and it wraps to 0 after reaching the vertical total field.
- R2: Bits [11:0] of register 0 hold the horizontal display end minus one, and bits [11:0] of register 2 hold the vertical display end minus one. `de` is high only inside the window from (0,0) to (horizontal end field, vertical end field), both ends included.
- R3: Register 1 holds the horizontal sync start minus one in bits [11:0] and the raw sync width in bits [27:16]. Horizontal sync is active for `pix_x` from the start field up to start field plus width minus one. Register 3 gives vertical sync the same rule on `pix_y`.
- R4: Control bit 2 sets the horizontal sync polarity and bit 3 sets the vertical sync polarity, where 1 means active high and 0 means active low. Each sync output is driven to its active level only while it is active.
- R5: Control bit 0 is timing enable. While the live bit is 0, `pix_x` and `pix_y` hold their values, both syncs sit at their inactive level and `de` is low.
- R6: Control bit 1 is plane enable. While the live bit is 0, `de` stays low over whole frames.
- R7: Register 4 is the control register. While the live timing enable is 1, a write to it leaves `ctrl_rd` unchanged until the vertical sync period following the write. The new value appears on `ctrl_rd` during the first line of that sync period.
- R8: While the live timing enable is 0, a control write shows on `ctrl_rd` two clock edges after the write edge, and not after the first.
- R9: Control bit 4 selects the pixel-clock launch edge. `pclk_fall` follows the live bit, where 1 selects the falling edge.
- R10: Control bits [31:5] are reserved and always read back as 0 on `ctrl_rd`.
- R11: After reset every timing field is 0, the live and pending control values are 0, `pix_x` and `pix_y` are 0, `de` is low, and both syncs are high, which is the inactive level for polarity 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register index 0 to 4 |
| wr_data | input | 32 | Register write value |
| hsync | output | 1 | Horizontal sync at its programmed polarity |
| vsync | output | 1 | Vertical sync at its programmed polarity |
| de | output | 1 | Data enable inside the active window |
| pix_x | output | 12 | Current pixel counter |
| pix_y | output | 12 | Current line counter |
| pclk_fall | output | 1 | Live pixel-clock edge select |
| ctrl_rd | output | 32 | Readback of the live control value |

## Verification
The raster is checked on a small mode of 10 by 6 counts whose visible area, sync start and sync length differ in every axis. On each cycle the bench checks the sync and data-enable levels against the current coordinates, so that an off-by-one in the start, end or width encoding shows up as a wrong level at one exact coordinate. The mode is scanned under several control patterns: active-high against active-low horizontal sync, plane enabled against plane disabled, and timing running against timing stopped. This separates the polarity gating, the enable gating and the counter hold from one another. Control writes are made both while the raster runs and while it is stopped. This tells the deferred path, which waits for vertical sync, from the immediate path, which takes two edges, and a write with all reserved bits set shows that those bits are masked.

// File: rtl/disp_timing_pkg.sv
package disp_timing_pkg;
  parameter int CNT_W  = 12;
  parameter int DATA_W = 32;
  parameter int ADDR_W = 3;
  parameter int HI_LSB = 16;

  localparam logic [ADDR_W-1:0] A_HTOT = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_HSYN = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_VTOT = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_VSYN = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(4);

  typedef struct packed {
    logic clk_fall;
    logic vs_high;
    logic hs_high;
    logic plane_on;
    logic timing_on;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/disp_regfile.sv
module disp_regfile
  import disp_timing_pkg::*;
#(
  parameter int CW = CNT_W,
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          vs_rise,
  output logic [CW-1:0] h_tot,
  output logic [CW-1:0] h_end,
  output logic [CW-1:0] h_ss,
  output logic [CW-1:0] h_sw,
  output logic [CW-1:0] v_tot,
  output logic [CW-1:0] v_end,
  output logic [CW-1:0] v_ss,
  output logic [CW-1:0] v_sw,
  output ctrl_t         live
);
  localparam int LO_MSB = CW - 1;
  localparam int HI_MSB = HI_LSB + CW - 1;

  logic [CW-1:0] h_tot_d, h_end_d, h_ss_d, h_sw_d;
  logic [CW-1:0] v_tot_d, v_end_d, v_ss_d, v_sw_d;
  ctrl_t         pend_q, pend_d, live_d;
  logic          pend_v_q, pend_v_d;
  logic          apply;
  logic          unused_ok;

  assign unused_ok = ^wr_data;
  assign apply     = pend_v_q && (vs_rise || !live.timing_on);

  always_comb begin
    h_tot_d  = h_tot;
    h_end_d  = h_end;
    h_ss_d   = h_ss;
    h_sw_d   = h_sw;
    v_tot_d  = v_tot;
    v_end_d  = v_end;
    v_ss_d   = v_ss;
    v_sw_d   = v_sw;
    pend_d   = pend_q;
    pend_v_d = pend_v_q;
    live_d   = live;
    if (apply) begin
      live_d   = pend_q;
      pend_v_d = 1'b0;
    end
    if (wr_en) begin
      unique case (wr_addr)
        A_HTOT: begin
          h_tot_d = wr_data[HI_MSB:HI_LSB];
          h_end_d = wr_data[LO_MSB:0];
        end
        A_HSYN: begin
          h_sw_d = wr_data[HI_MSB:HI_LSB];
          h_ss_d = wr_data[LO_MSB:0];
        end
        A_VTOT: begin
          v_tot_d = wr_data[HI_MSB:HI_LSB];
          v_end_d = wr_data[LO_MSB:0];
        end
        A_VSYN: begin
          v_sw_d = wr_data[HI_MSB:HI_LSB];
          v_ss_d = wr_data[LO_MSB:0];
        end
        A_CTRL: begin
          pend_d   = ctrl_t'(wr_data[CTRL_W-1:0]);
          pend_v_d = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_tot    <= '0;
      h_end    <= '0;
      h_ss     <= '0;
      h_sw     <= '0;
      v_tot    <= '0;
      v_end    <= '0;
      v_ss     <= '0;
      v_sw     <= '0;
      pend_q   <= '0;
      pend_v_q <= 1'b0;
      live     <= '0;
    end else begin
      h_tot    <= h_tot_d;
      h_end    <= h_end_d;
      h_ss     <= h_ss_d;
      h_sw     <= h_sw_d;
      v_tot    <= v_tot_d;
      v_end    <= v_end_d;
      v_ss     <= v_ss_d;
      v_sw     <= v_sw_d;
      pend_q   <= pend_d;
      pend_v_q <= pend_v_d;
      live     <= live_d;
    end
  end

  // R7: with nothing pending, the live control copy cannot move
  p_live_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_v_q |=> $stable(live));
endmodule

// File: rtl/disp_counter.sv
module disp_counter #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [CW-1:0] h_tot,
  input  logic [CW-1:0] v_tot,
  output logic [CW-1:0] hcnt,
  output logic [CW-1:0] vcnt
);
  logic [CW-1:0] hcnt_d, vcnt_d;
  logic          h_wrap, v_wrap;

  assign h_wrap = (hcnt >= h_tot);
  assign v_wrap = (vcnt >= v_tot);

  always_comb begin
    hcnt_d = hcnt;
    vcnt_d = vcnt;
    if (en) begin
      if (h_wrap) begin
        hcnt_d = '0;
        vcnt_d = v_wrap ? '0 : vcnt + 1'b1;
      end else begin
        hcnt_d = hcnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt <= '0;
      vcnt <= '0;
    end else begin
      hcnt <= hcnt_d;
      vcnt <= vcnt_d;
    end
  end

  // R5: counters hold while timing is stopped
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(hcnt) && $stable(vcnt));

  // R1: pixel counter returns to zero after the total
  p_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    en && (hcnt >= h_tot) |=> hcnt == '0);
endmodule

// File: rtl/disp_axis_cmp.sv
module disp_axis_cmp #(
  parameter int CW = 12
) (
  input  logic          en,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] start,
  input  logic [CW-1:0] len,
  output logic          act
);
  logic [CW:0] stop;

  assign stop = {1'b0, start} + {1'b0, len};
  assign act  = en && (cnt >= start) && ({1'b0, cnt} < stop);
endmodule

// File: rtl/disp_timing_gen.sv
module disp_timing_gen
  import disp_timing_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              hsync,
  output logic              vsync,
  output logic              de,
  output logic [CNT_W-1:0]  pix_x,
  output logic [CNT_W-1:0]  pix_y,
  output logic              pclk_fall,
  output logic [DATA_W-1:0] ctrl_rd
);
  localparam int NAX = 2;

  logic [CNT_W-1:0] h_tot, h_end, h_ss, h_sw;
  logic [CNT_W-1:0] v_tot, v_end, v_ss, v_sw;
  logic [CNT_W-1:0] hcnt, vcnt;
  ctrl_t            live;
  logic             vs_rise;
  logic             vact_q, vact_d;

  logic [CNT_W-1:0] ax_cnt   [NAX];
  logic [CNT_W-1:0] ax_start [NAX];
  logic [CNT_W-1:0] ax_len   [NAX];
  logic             ax_pol   [NAX];
  logic             ax_act   [NAX];
  logic             ax_out   [NAX];

  disp_regfile #(.CW(CNT_W), .DW(DATA_W), .AW(ADDR_W)) regs_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .vs_rise (vs_rise),
    .h_tot   (h_tot),
    .h_end   (h_end),
    .h_ss    (h_ss),
    .h_sw    (h_sw),
    .v_tot   (v_tot),
    .v_end   (v_end),
    .v_ss    (v_ss),
    .v_sw    (v_sw),
    .live    (live)
  );

  disp_counter #(.CW(CNT_W)) cnt_i (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (live.timing_on),
    .h_tot (h_tot),
    .v_tot (v_tot),
    .hcnt  (hcnt),
    .vcnt  (vcnt)
  );

  assign ax_cnt[0]   = hcnt;
  assign ax_start[0] = h_ss;
  assign ax_len[0]   = h_sw;
  assign ax_pol[0]   = live.hs_high;
  assign ax_cnt[1]   = vcnt;
  assign ax_start[1] = v_ss;
  assign ax_len[1]   = v_sw;
  assign ax_pol[1]   = live.vs_high;

  for (genvar g = 0; g < NAX; g++) begin : g_axis
    disp_axis_cmp #(.CW(CNT_W)) cmp_i (
      .en    (live.timing_on),
      .cnt   (ax_cnt[g]),
      .start (ax_start[g]),
      .len   (ax_len[g]),
      .act   (ax_act[g])
    );
    assign ax_out[g] = ax_pol[g] ? ax_act[g] : !ax_act[g];
  end

  assign vact_d  = ax_act[1];
  assign vs_rise = ax_act[1] && !vact_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vact_q <= 1'b0;
    else        vact_q <= vact_d;
  end

  assign hsync     = ax_out[0];
  assign vsync     = ax_out[1];
  assign de        = live.timing_on && live.plane_on &&
                     (hcnt <= h_end) && (vcnt <= v_end);
  assign pix_x     = hcnt;
  assign pix_y     = vcnt;
  assign pclk_fall = live.clk_fall;
  assign ctrl_rd   = {{(DATA_W-CTRL_W){1'b0}}, live};

  // R5: stopped timing leaves both sync comparators idle
  p_idle_inactive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !live.timing_on |-> !ax_act[0] && !ax_act[1]);

  // R2: data enable only inside the active window
  p_de_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
    de |-> (pix_x <= h_end) && (pix_y <= v_end));
endmodule

// File: tb/disp_timing_gen_tb_top.sv
`timescale 1ns/1ps
module disp_timing_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  wr_addr;
  logic [31:0] wr_data;
  logic        hsync, vsync, de, pclk_fall;
  logic [11:0] pix_x, pix_y;
  logic [31:0] ctrl_rd;

  int n_chk = 0;
  int n_fail = 0;

  localparam int HT = 9, HE = 5, HS = 7, HW = 2;
  localparam int VT = 5, VE = 2, VS = 3, VH = 1;

  always #4 clk = ~clk;

  disp_timing_gen dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .hsync(hsync), .vsync(vsync), .de(de),
    .pix_x(pix_x), .pix_y(pix_y), .pclk_fall(pclk_fall), .ctrl_rd(ctrl_rd)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic poll_ctrl(input logic [31:0] want, input string tag);
    int k;
    k = 0;
    while (ctrl_rd !== want && k < 400) begin
      @(negedge clk);
      k++;
    end
    chk(ctrl_rd === want, tag, int'(ctrl_rd), int'(want));
  endtask

  task automatic t_reset;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(hsync === 1'b1, "R11 hsync", int'(hsync), 1);
    chk(vsync === 1'b1, "R11 vsync", int'(vsync), 1);
    chk(de === 1'b0, "R11 de", int'(de), 0);
    chk(pix_x === 0 && pix_y === 0, "R11 counters", int'({pix_y, pix_x}), 0);
    chk(ctrl_rd === 0, "R11 ctrl", int'(ctrl_rd), 0);
    @(negedge clk);
    chk(pix_x === 0, "R11 idle hold", int'(pix_x), 0);
  endtask

  // R8: immediate apply while stopped, two edges after the write edge
  task automatic t_program;
    wr(3'd0, (32'(HT) << 16) | 32'(HE));
    wr(3'd1, (32'(HW) << 16) | 32'(HS));
    wr(3'd2, (32'(VT) << 16) | 32'(VE));
    wr(3'd3, (32'(VH) << 16) | 32'(VS));
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'd4; wr_data = 32'h7;
    @(negedge clk);
    wr_en = 1'b0;
    chk(ctrl_rd === 0, "R8 not after one edge", int'(ctrl_rd), 0);
    @(negedge clk);
    chk(ctrl_rd === 32'h7, "R8 applied after two edges", int'(ctrl_rd), 7);
  endtask

  // R1 R2 R3 R4 R6: cycle-by-cycle raster scan
  task automatic t_scan(input bit hpol, input bit vpol, input bit plane, input int ncyc);
    int px, py;
    bit hact, vact, dexp;
    @(negedge clk);
    px = int'(pix_x); py = int'(pix_y);
    for (int i = 0; i < ncyc; i++) begin
      @(negedge clk);
      chk(int'(pix_x) == ((px >= HT) ? 0 : px + 1), "R1 pix_x step", int'(pix_x),
          (px >= HT) ? 0 : px + 1);
      if (px >= HT)
        chk(int'(pix_y) == ((py >= VT) ? 0 : py + 1), "R1 pix_y step", int'(pix_y),
            (py >= VT) ? 0 : py + 1);
      else
        chk(int'(pix_y) == py, "R1 pix_y hold", int'(pix_y), py);
      px = int'(pix_x); py = int'(pix_y);
      hact = (px >= HS) && (px < HS + HW);
      vact = (py >= VS) && (py < VS + VH);
      dexp = plane && (px <= HE) && (py <= VE);
      chk(hsync === (hpol ? hact : !hact), "R3 R4 hsync", int'(hsync), int'(hpol ? hact : !hact));
      chk(vsync === (vpol ? vact : !vact), "R3 R4 vsync", int'(vsync), int'(vpol ? vact : !vact));
      chk(de === dexp, plane ? "R2 de window" : "R6 plane off", int'(de), int'(dexp));
    end
  endtask

  // R7 R9: deferred apply at vertical sync
  task automatic t_shadow;
    int k;
    k = 0;
    while (pix_y !== 0 && k < 200) begin @(negedge clk); k++; end
    wr(3'd4, 32'h13);
    for (int i = 0; i < 5; i++) begin
      chk(ctrl_rd === 32'h7, "R7 old value held", int'(ctrl_rd), 7);
      @(negedge clk);
    end
    poll_ctrl(32'h13, "R7 new value reaches live");
    chk(int'(pix_y) == VS, "R7 applied on sync line", int'(pix_y), VS);
    chk(pclk_fall === 1'b1, "R9 falling edge select", int'(pclk_fall), 1);
  endtask

  // R10 R9: reserved bits masked, clock phase back to rising
  task automatic t_reserved;
    wr(3'd4, 32'hFFFF_FFE3);
    poll_ctrl(32'h3, "R10 reserved bits read zero");
    chk(pclk_fall === 1'b0, "R9 rising edge select", int'(pclk_fall), 0);
  endtask

  task automatic t_plane_off;
    wr(3'd4, 32'h1);
    poll_ctrl(32'h1, "R6 plane off applied");
  endtask

  // R5: stopping the raster
  task automatic t_disable;
    int sx, sy;
    wr(3'd4, 32'h0);
    poll_ctrl(32'h0, "R5 disable applied");
    sx = int'(pix_x); sy = int'(pix_y);
    repeat (6) @(negedge clk);
    chk(int'(pix_x) == sx && int'(pix_y) == sy, "R5 counters hold",
        int'({pix_y, pix_x}), int'({sy[11:0], sx[11:0]}));
    chk(hsync === 1'b1, "R5 hsync inactive", int'(hsync), 1);
    chk(vsync === 1'b1, "R5 vsync inactive", int'(vsync), 1);
    chk(de === 1'b0, "R5 de low", int'(de), 0);
  endtask

  bit done = 0;

  initial begin
    t_reset;
    t_program;
    t_scan(1'b1, 1'b0, 1'b1, 130);
    t_shadow;
    t_scan(1'b0, 1'b0, 1'b1, 130);
    t_reserved;
    t_scan(1'b0, 1'b0, 1'b1, 70);
    t_plane_off;
    t_scan(1'b0, 1'b0, 1'b0, 130);
    t_disable;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule